// File: doc/BRIEF.md
# 64-bit Compare Timer

This block is a free-running 64-bit up-counter paired with a 64-bit comparator, a sticky match flag and an interrupt line, all reached through 32-bit registers on a simple single-cycle read/write bus. The counter advances by one on every cycle in which the tick-enable input is high and the counter is enabled. Whenever the comparator is enabled and the count is at or above the comparator value, a match event is raised. The event sets a status flag that stays set until software clears it, and it can drive the interrupt output.

An auto-increment mode adds a programmed 32-bit step to the comparator on every event, so the block produces periodic interrupts without software rewriting the comparator. Software reads the 64-bit count as two halves using a high, low, high sequence. Because the carry from the low word into the high word happens in the same cycle, that sequence always yields a consistent value. The comparator has its own enable, so software can retarget it safely: it clears the enable, writes both halves, then sets the enable again.

Registers are selected by a word index, which is the byte offset divided by four: 0 count low, 1 count high, 2 control, 3 status, 4 comparator low, 5 comparator high, 6 step. Index 7 is unmapped.

Top module: `glb_timer`

## Requirements
- R1: After a synchronous reset, the count, comparator, step, control and status registers are zero, `irq` is low and `bus_rdata` is zero.
- R2: With the counter enable (control bit 0) set, the count rises by exactly one in each cycle where `tick` is high. With `tick` low or the counter enable clear, the count holds.
- R3: A tick that carries out of the low word updates the high word in the same cycle. For example, after three ticks from 0x1_FFFFFFFE the halves read high 0x2 and low 0x1.
- R4: Writes to index 0 (low word) or index 1 (high word) preset the count only while the counter enable is clear. While the counter is enabled, such writes are ignored.
- R5: The control register at index 2 holds bit 0 counter enable, bit 1 comparator enable, bit 2 interrupt enable and bit 3 auto-increment, and it reads back as written.
- R6: When the comparator enable is set and the count is greater than or equal to the comparator, the status flag (index 3, bit 0) becomes 1 in the next cycle.
- R7: The status flag is sticky. Writing 1 to bit 0 of index 3 clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R8: `irq` is registered and always equals the status flag ANDed with the interrupt enable (control bit 2).
- R9: With the comparator enable clear, no event occurs, whatever the count and comparator values. This makes rewriting the comparator halves (indices 4 and 5) safe.
- R10: With auto-increment set, each event adds the step register (index 6, zero-extended) to the comparator in the cycle it fires. A bus write to either comparator half in that same cycle takes precedence over the increment.
- R11: A read returns its data on `bus_rdata` one cycle after the request, and `bus_rdata` holds until the next read. Index 7 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse from an external prescaler |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W (3) | Register word index |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Registered read data |
| irq | output | 1 | Interrupt, status AND interrupt enable |

## Verification
The bench builds the block with its defaults: a 32-bit bus, which gives a 64-bit count, and a 3-bit register index. A 32-bit low word lets a count preset just below 2^32 reach the carry into the high half in three ticks. The full index width also brings the unmapped slot 7 within reach. A small comparator and step then let a 40-tick run exercise several auto-increment events and the catch-up behaviour once the count stops.

// File: rtl/glb_timer_pkg.sv
package glb_timer_pkg;

  typedef enum logic [2:0] {
    RG_CNT_LO = 3'd0,
    RG_CNT_HI = 3'd1,
    RG_CTRL   = 3'd2,
    RG_STAT   = 3'd3,
    RG_CMP_LO = 3'd4,
    RG_CMP_HI = 3'd5,
    RG_STEP   = 3'd6
  } reg_idx_e;

  localparam int RG_NUM = 7;

  typedef struct packed {
    logic autoinc;
    logic irq_en;
    logic cmp_en;
    logic cnt_en;
  } ctrl_t;

endpackage

// File: rtl/glb_timer_bus.sv
module glb_timer_bus
  import glb_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [IDX_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic [2*BUS_W-1:0]   cnt_q,
  input  logic [2*BUS_W-1:0]   cmp_q,
  input  logic                 status_q,
  output logic [RG_NUM-1:0]    wr_stb,
  output ctrl_t                ctrl_q,
  output ctrl_t                ctrl_d,
  output logic [BUS_W-1:0]     step_q,
  output logic [BUS_W-1:0]     bus_rdata
);

  localparam int CNT_W = 2 * BUS_W;

  logic [BUS_W-1:0] rd_val;

  // one write strobe per mapped register
  for (genvar g = 0; g < RG_NUM; g++) begin : g_stb
    assign wr_stb[g] = bus_sel && bus_wr && (bus_addr == IDX_W'(g));
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_stb[RG_CTRL]) ctrl_d = ctrl_t'(bus_wdata[3:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      step_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_stb[RG_STEP]) step_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      IDX_W'(RG_CNT_LO): rd_val = cnt_q[BUS_W-1:0];
      IDX_W'(RG_CNT_HI): rd_val = cnt_q[CNT_W-1:BUS_W];
      IDX_W'(RG_CTRL):   rd_val = {{(BUS_W-4){1'b0}}, ctrl_q};
      IDX_W'(RG_STAT):   rd_val = {{(BUS_W-1){1'b0}}, status_q};
      IDX_W'(RG_CMP_LO): rd_val = cmp_q[BUS_W-1:0];
      IDX_W'(RG_CMP_HI): rd_val = cmp_q[CNT_W-1:BUS_W];
      IDX_W'(RG_STEP):   rd_val = step_q;
      default:           rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/glb_timer_count.sv
module glb_timer_count #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [BUS_W-1:0]   wdata,
  output logic [2*BUS_W-1:0] cnt_q
);

  localparam int CNT_W = 2 * BUS_W;

  // full-width adder: the carry reaches the upper half in the same cycle
  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      if (tick) cnt_q <= cnt_inc;
    end else begin
      if (wr_lo) cnt_q[BUS_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:BUS_W] <= wdata;
    end
  end

endmodule

// File: rtl/glb_timer_match.sv
module glb_timer_match #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*BUS_W-1:0] cnt_q,
  input  logic               cmp_en,
  input  logic               autoinc,
  input  logic               ien_d,
  input  logic [BUS_W-1:0]   step_q,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_stat,
  input  logic [BUS_W-1:0]   wdata,
  output logic [2*BUS_W-1:0] cmp_q,
  output logic               status_q,
  output logic               evt,
  output logic               irq_q
);

  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cmp_d;
  logic             stat_d;

  // compares the registered count, so a tick past the target still matches
  assign evt = cmp_en && (cnt_q >= cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) cmp_d[BUS_W-1:0]     = wdata;
      if (wr_hi) cmp_d[CNT_W-1:BUS_W] = wdata;
    end else if (evt && autoinc) begin
      cmp_d = cmp_q + {{BUS_W{1'b0}}, step_q};
    end
  end

  always_comb begin
    stat_d = status_q;
    if (evt)                    stat_d = 1'b1;
    else if (wr_stat && wdata[0]) stat_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q    <= '0;
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cmp_q    <= cmp_d;
      status_q <= stat_d;
      irq_q    <= stat_d && ien_d;
    end
  end

endmodule

// File: rtl/glb_timer.sv
module glb_timer
  import glb_timer_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq
);

  localparam int CNT_W = 2 * BUS_W;

  logic [RG_NUM-1:0] wr_stb;
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_d;
  logic [BUS_W-1:0]  step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              status_q;
  logic              evt;

  glb_timer_bus #(.BUS_W(BUS_W), .IDX_W(IDX_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .status_q  (status_q),
    .wr_stb    (wr_stb),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .step_q    (step_q),
    .bus_rdata (bus_rdata)
  );

  glb_timer_count #(.BUS_W(BUS_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl_q.cnt_en),
    .tick  (tick),
    .wr_lo (wr_stb[RG_CNT_LO]),
    .wr_hi (wr_stb[RG_CNT_HI]),
    .wdata (bus_wdata),
    .cnt_q (cnt_q)
  );

  glb_timer_match #(.BUS_W(BUS_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .cnt_q    (cnt_q),
    .cmp_en   (ctrl_q.cmp_en),
    .autoinc  (ctrl_q.autoinc),
    .ien_d    (ctrl_d.irq_en),
    .step_q   (step_q),
    .wr_lo    (wr_stb[RG_CMP_LO]),
    .wr_hi    (wr_stb[RG_CMP_HI]),
    .wr_stat  (wr_stb[RG_STAT]),
    .wdata    (bus_wdata),
    .cmp_q    (cmp_q),
    .status_q (status_q),
    .evt      (evt),
    .irq_q    (irq)
  );

endmodule

// File: rtl/glb_timer_chk.sv
module glb_timer_chk #(
  parameter int BUS_W = 32,
  parameter int IDX_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [IDX_W-1:0]   bus_addr,
  input logic               wdata0,
  input logic [2*BUS_W-1:0] cnt,
  input logic [2*BUS_W-1:0] cmp,
  input logic [BUS_W-1:0]   step,
  input logic [3:0]         ctrl,
  input logic               status,
  input logic               evt,
  input logic               irq
);

  logic cnt_wr, cmp_wr, stat_clr;
  assign cnt_wr   = bus_sel && bus_wr && (bus_addr == IDX_W'(0) || bus_addr == IDX_W'(1));
  assign cmp_wr   = bus_sel && bus_wr && (bus_addr == IDX_W'(4) || bus_addr == IDX_W'(5));
  assign stat_clr = bus_sel && bus_wr && (bus_addr == IDX_W'(3)) && wdata0;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && tick) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!(ctrl[0] && tick) && !cnt_wr) |=> $stable(cnt));

  p_run_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && !tick && cnt_wr) |=> $stable(cnt));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (status && !stat_clr) |=> status);

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == (status && ctrl[2])));

  p_no_event_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[1] && !status) |=> !status);

  p_autoinc_r10: assert property (@(posedge clk) disable iff (rst)
    (evt && ctrl[3] && !cmp_wr) |=> (cmp == $past(cmp) + {{BUS_W{1'b0}}, $past(step)}));

endmodule

bind glb_timer glb_timer_chk #(.BUS_W(BUS_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wdata0   (bus_wdata[0]),
  .cnt      (cnt_q),
  .cmp      (cmp_q),
  .step     (step_q),
  .ctrl     (ctrl_q),
  .status   (status_q),
  .evt      (evt),
  .irq      (irq)
);

// File: tb/glb_timer_bench.sv
module glb_timer_bench;

  localparam int BUS_W = 32;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic             bus_sel = 1'b0;
  logic             bus_wr = 1'b0;
  logic [IDX_W-1:0] bus_addr = '0;
  logic [BUS_W-1:0] bus_wdata = '0;
  logic [BUS_W-1:0] bus_rdata;
  logic             irq;

  glb_timer #(.BUS_W(BUS_W), .IDX_W(IDX_W)) u_glb_timer (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;   // 50 MHz

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step, m_rd;
  logic [3:0]  m_ctrl;
  logic        m_stat, m_irq, m_ev;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_rd = 0;
      m_ctrl = 0; m_stat = 0; m_irq = 0;
    end else begin
      m_ev = m_ctrl[1] && (m_cnt >= m_cmp);
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          0: m_rd = m_cnt[31:0];
          1: m_rd = m_cnt[63:32];
          2: m_rd = {28'd0, m_ctrl};
          3: m_rd = {31'd0, m_stat};
          4: m_rd = m_cmp[31:0];
          5: m_rd = m_cmp[63:32];
          6: m_rd = m_step;
          default: m_rd = 0;
        endcase
      end
      if (m_ev) m_stat = 1;
      else if (bus_sel && bus_wr && bus_addr == 3 && bus_wdata[0]) m_stat = 0;
      if (bus_sel && bus_wr && (bus_addr == 4 || bus_addr == 5)) begin
        if (bus_addr == 4) m_cmp[31:0] = bus_wdata;
        else m_cmp[63:32] = bus_wdata;
      end else if (m_ev && m_ctrl[3]) m_cmp = m_cmp + {32'd0, m_step};
      if (m_ctrl[0]) begin
        if (tick) m_cnt = m_cnt + 1;
      end else if (bus_sel && bus_wr && bus_addr == 0) m_cnt[31:0] = bus_wdata;
      else if (bus_sel && bus_wr && bus_addr == 1) m_cnt[63:32] = bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 2) m_ctrl = bus_wdata[3:0];
      if (bus_sel && bus_wr && bus_addr == 6) m_step = bus_wdata;
      m_irq = m_stat && m_ctrl[2];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "rdata vs model", bus_rdata, m_rd);
      chk(cur_req, "irq vs model", irq, m_irq);
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = idx[IDX_W-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = idx[IDX_W-1:0];
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog run did not finish actual %0d expected <20000", cycles);
      finish_run();
    end
  end

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "rdata after reset", bus_rdata, 0);
    chk("R1", "irq after reset", irq, 0);
    rd(2, v); chk("R1", "ctrl after reset", v, 0);
    rd(5, v); chk("R1", "cmp hi after reset", v, 0);

    // R4 preset while stopped
    cur_req = "R4";
    wr(0, 32'hFFFF_FFFE);
    wr(1, 32'h0000_0001);
    rd(0, v); chk("R4", "preset low", v, 32'hFFFF_FFFE);
    rd(1, v); chk("R4", "preset high", v, 1);

    // R3 carry, R2 counting
    cur_req = "R3";
    wr(2, 32'h1);
    ticks(3);
    rd(1, v); chk("R3", "high after carry", v, 2);
    rd(0, v); chk("R3", "low after carry", v, 1);
    cur_req = "R2";
    repeat (5) @(negedge clk);
    rd(0, v); chk("R2", "hold without tick", v, 1);

    // R4 write while running ignored
    cur_req = "R4";
    wr(0, 32'h0);
    rd(0, v); chk("R4", "write while running", v, 1);
    rd(2, v); chk("R5", "ctrl readback", v, 1);

    // R6 event, R8 irq
    cur_req = "R6";
    wr(4, 32'h10);
    wr(5, 32'h2);
    wr(2, 32'h7);
    ticks(20);
    repeat (2) @(negedge clk);
    chk("R8", "irq after event", irq, 1);
    rd(3, v); chk("R6", "status set", v, 1);
    rd(2, v); chk("R5", "ctrl readback 7", v, 7);

    // R7 clear rules
    cur_req = "R7";
    wr(3, 32'h0);
    rd(3, v); chk("R7", "write 0 keeps flag", v, 1);
    wr(3, 32'h1);
    rd(3, v); chk("R7", "event beats clear", v, 1);
    wr(2, 32'h5);
    wr(3, 32'h1);
    rd(3, v); chk("R7", "cleared", v, 0);
    chk("R8", "irq low after clear", irq, 0);

    // R9 disabled comparator never fires
    cur_req = "R9";
    wr(4, 32'h0);
    repeat (4) @(negedge clk);
    rd(3, v); chk("R9", "no event when disabled", v, 0);
    chk("R9", "irq low when disabled", irq, 0);

    // R8 flag without interrupt enable
    cur_req = "R8";
    wr(2, 32'h3);
    repeat (2) @(negedge clk);
    chk("R8", "irq masked", irq, 0);
    rd(3, v); chk("R6", "flag with irq masked", v, 1);

    // R10 auto-increment
    cur_req = "R10";
    wr(2, 32'h0);
    wr(3, 32'h1);
    wr(0, 32'h0);
    wr(1, 32'h0);
    wr(4, 32'd5);
    wr(5, 32'h0);
    wr(6, 32'd10);
    wr(2, 32'hF);
    ticks(40);
    repeat (4) @(negedge clk);
    rd(4, v); chk("R10", "cmp low after periodic events", v, 45);
    rd(5, v); chk("R10", "cmp high after periodic events", v, 0);
    rd(0, v); chk("R2", "count after 40 ticks", v, 40);
    chk("R8", "irq periodic", irq, 1);

    // R11 unmapped slot
    cur_req = "R11";
    rd(7, v); chk("R11", "unmapped read", v, 0);
    wr(7, 32'hFFFF_FFFF);
    rd(6, v); chk("R11", "step unchanged", v, 10);
    rd(2, v); chk("R11", "ctrl unchanged", v, 32'hF);
    repeat (3) @(negedge clk);
    chk("R11", "rdata holds", bus_rdata, 32'hF);

    finish_run();
  end

endmodule